// File: doc/BRIEF.md
# Serial Control-Register Access Slave

This block is the two-wire serial slave that gives a host access to a bank of eight byte-wide control registers. It resynchronises and deglitches the bus clock and data lines with the system clock. It recognises start, repeated start and stop conditions, and it answers a single fixed 7-bit device address. The first byte after a write-addressed header loads a register pointer. The bytes after it are written to the register under the pointer, one register per byte.

Reads send register contents MSB first, beginning at the current pointer. The pointer advances after every byte that is transferred, and it wraps from the highest register back to zero. It keeps its value between transactions. As a result, a read with no pointer write in front of it carries on from the register after the last one accessed.

Toward the register bank the block presents a parallel port. This port has an address, write data, a one-cycle write strobe and combinational read data. While the external active-low reset is held, both bus inputs are forced high inside the block, so no bus activity can reach the logic.

Top module: `ctl_i2c_slave`

## Requirements
- R1: The device answers only to the 7-bit address 0001001b, which is header byte 0x12 for write and 0x13 for read (R/W in bit 0). It acknowledges a matching header by pulling SDA low for the ninth clock.
- R2: A header with any other address gets no acknowledge. The block then drives nothing and writes nothing until the next START, even if more bytes follow.
- R3: In a write, the second byte sets the pointer (its low 3 bits) and is acknowledged. Every later byte is acknowledged and written with one single-cycle strobe to the pointer address, and the pointer then advances by one.
- R4: Advancing the pointer from 7 gives 0, in writes and in reads.
- R5: The pointer survives STOP. A read header with no pointer write before it returns data starting at the pointer, which is the register after the last one accessed. After reset the pointer is 0.
- R6: A write header followed by a pointer byte, then a repeated START and a read header, returns data starting at that pointer.
- R7: Read data is shifted out MSB first, changing while SCL is low. A master ACK after a byte makes the block send the next register. A master NACK releases SDA, and the block then waits for STOP or START.
- R8: A STOP or START seen in any state aborts the byte in progress. It releases SDA and leaves the pointer unchanged, and no partial byte is written.
- R9: While ext_rst_n is low, the block never drives SDA and never strobes a write, whatever the bus does.
- R10: A pulse on SCL or SDA that is shorter than FILT_LEN system clocks is ignored and neither adds a bit nor makes a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| ext_rst_n | input | 1 | External active-low reset; also gates the bus inputs high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_addr | output | 3 | Register address: the write address during a strobe, the pointer otherwise |
| reg_wdata | output | 8 | Data to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data of register reg_addr, combinational |

## Verification
A corrupted pointer only shows up later, as data read from the wrong register or written to the wrong one. For that reason every write burst is followed by a read-back, and abort cases are followed by a plain read whose first byte shows where the pointer stands. A wrong state in the byte engine shows up within one bus bit. It appears as a missing or spurious acknowledge on the ninth clock, as SDA still held after STOP, or as a write strobe on an aborted byte.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } eng_state_t;

  // header byte carries the 7-bit device address above the R/W bit
  function automatic logic addr_hit(input logic [6:0] dev, input logic [7:0] hdr);
    return hdr[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], pin};
      if (sync_q[1] == clean) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        clean <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  generate
    if (FILT_LEN >= 2) begin : g_chk
      // R10: a filtered level lasts at least two cycles
      a_r10_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |=> (clean == $past(clean)));
    end
  endgenerate
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h09,
  parameter int         NREG     = 8,
  parameter int         AW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          sda_in,
  input  logic [7:0]    reg_rdata,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  eng_state_t    st;
  logic [3:0]    bitcnt;
  logic [7:0]    rx_sr, tx_sr;
  logic          rw_q, mack_q;
  logic [AW-1:0] ptr, wr_addr;

  // named internal events
  logic byte_in, ptr_load, ptr_step;
  assign byte_in  = scl_fall && (bitcnt == 4'd8);
  assign ptr_load = byte_in && (st == ST_PTR);
  assign ptr_step = byte_in && (st == ST_WDAT || st == ST_RDAT);

  assign reg_addr = reg_we ? wr_addr : ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bitcnt    <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      ptr       <= '0;
      wr_addr   <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (start_ev) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        unique case (st)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            rx_sr  <= {rx_sr[6:0], sda_in};
            bitcnt <= bitcnt + 4'd1;
          end
          ST_RDAT: bitcnt <= bitcnt + 4'd1;
          ST_RACK: mack_q <= ~sda_in;
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (st)
          ST_ADDR: if (bitcnt == 4'd8) begin
            if (addr_hit(DEV_ADDR, rx_sr)) begin
              sda_oe <= 1'b1;
              rw_q   <= rx_sr[0];
              st     <= ST_ADDR_ACK;
            end else begin
              st <= ST_SKIP;
            end
          end
          ST_PTR: if (bitcnt == 4'd8) begin
            sda_oe <= 1'b1;
            ptr    <= rx_sr[AW-1:0];
            st     <= ST_PTR_ACK;
          end
          ST_WDAT: if (bitcnt == 4'd8) begin
            sda_oe    <= 1'b1;
            reg_we    <= 1'b1;
            reg_wdata <= rx_sr;
            wr_addr   <= ptr;
            ptr       <= next_ptr(ptr);
            st        <= ST_WDAT_ACK;
          end
          ST_ADDR_ACK: begin
            bitcnt <= '0;
            if (rw_q) begin
              tx_sr  <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              st     <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_PTR;
            end
          end
          ST_PTR_ACK, ST_WDAT_ACK: begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            st     <= ST_WDAT;
          end
          ST_RDAT: begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              ptr    <= next_ptr(ptr);
              st     <= ST_RACK;
            end else begin
              tx_sr  <= {tx_sr[6:0], 1'b0};
              sda_oe <= ~tx_sr[6];
            end
          end
          ST_RACK: begin
            if (mack_q) begin
              tx_sr  <= reg_rdata;
              sda_oe <= ~reg_rdata[7];
              bitcnt <= '0;
              st     <= ST_RDAT;
            end else begin
              st <= ST_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_ack_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR_ACK) |-> sda_oe);
  a_r2_quiet_when_skipping: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP || st == ST_IDLE) |-> !sda_oe);
  a_r3_we_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r3_we_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($past(st) == ST_WDAT));
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_step && ptr == LAST) |=> (ptr == '0));
  a_r5_ptr_only_moves_on_events: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> $past(ptr_load || ptr_step));
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_oe && st == ST_IDLE));
endmodule

// File: rtl/ctl_i2c_slave.sv
module ctl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h09,
  parameter int         NREG     = 8,
  parameter int         FILT_LEN = 3,
  parameter int         AW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          ext_rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  input  logic [7:0]    reg_rdata
);
  localparam int L_SDA = 0;
  localparam int L_SCL = 1;

  // input buffers held high while the reset pin is low
  logic [1:0] raw, clean;
  assign raw[L_SCL] = scl_i | ~ext_rst_n;
  assign raw[L_SDA] = sda_i | ~ext_rst_n;

  for (genvar i = 0; i < 2; i++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_n (ext_rst_n),
      .pin   (raw[i]),
      .clean (clean[i])
    );
  end

  logic scl_q, sda_q;
  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= clean[L_SCL];
      sda_q <= clean[L_SDA];
    end
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = clean[L_SCL] & ~scl_q;
  assign scl_fall = ~clean[L_SCL] & scl_q;
  assign start_ev = clean[L_SCL] & scl_q & sda_q & ~clean[L_SDA];
  assign stop_ev  = clean[L_SCL] & scl_q & ~sda_q & clean[L_SDA];

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .AW(AW)) u_eng (
    .clk       (clk),
    .rst_n     (ext_rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_in    (clean[L_SDA]),
    .reg_rdata (reg_rdata),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we)
  );

  a_r8_conditions_exclusive: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !(start_ev && stop_ev) && !((start_ev || stop_ev) && (scl_rise || scl_fall)));
endmodule

// File: tb/ctl_i2c_slave_tb.sv
`timescale 1ns/1ps
module ctl_i2c_slave_tb;
  localparam int Q = 10;  // quarter SCL period in system clocks

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       ext_rst_n = 1'b0;
  logic       mst_scl = 1'b1, mst_sda = 1'b1;
  logic       sda_oe, reg_we;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sda_bus;

  assign sda_bus = mst_sda & ~sda_oe;

  ctl_i2c_slave u_dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .scl_i(mst_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  // register bank attached to the port, plus bench model
  logic [7:0] mem [8];
  logic [7:0] exp_mem [8];
  logic [2:0] exp_ptr;
  int         we_cnt = 0;
  int         checks = 0, failures = 0;
  bit         done = 0;

  assign reg_rdata = mem[reg_addr];

  initial for (int i = 0; i < 8; i++) begin
    mem[i]     = 8'(i * 37 + 5);
    exp_mem[i] = 8'(i * 37 + 5);
  end

  always @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  function automatic logic [2:0] step(input logic [2:0] p);
    return (p == 3'd7) ? 3'd0 : p + 3'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    mst_sda = 1; mst_scl = 1; w(Q); mst_sda = 0; w(Q); mst_scl = 0; w(Q);
  endtask
  task automatic bus_rstart();
    mst_sda = 1; w(Q); mst_scl = 1; w(Q); mst_sda = 0; w(Q); mst_scl = 0; w(Q);
  endtask
  task automatic bus_stop();
    mst_sda = 0; w(Q); mst_scl = 1; w(Q); mst_sda = 1; w(Q);
  endtask
  task automatic wbit(input logic b, input bit glitch);
    mst_sda = b; w(Q / 2);
    if (glitch) begin mst_scl = 1; w(1); mst_scl = 0; end
    w(Q - Q / 2);
    mst_scl = 1; w(Q);
    if (glitch) begin mst_sda = ~b; w(1); mst_sda = b; end
    w(Q);
    mst_scl = 0; w(Q);
  endtask
  task automatic rbit(output logic b);
    mst_sda = 1; w(Q); mst_scl = 1; w(Q); b = sda_bus; w(Q); mst_scl = 0; w(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack, input bit glitch = 0);
    for (int i = 7; i >= 0; i--) wbit(d[i], glitch);
    rbit(ack);
  endtask
  task automatic rbyte(output logic [7:0] d, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(~mack, 0);
  endtask

  task automatic do_write(input logic [7:0] p, input int n, input string req, input bit glitch = 0);
    logic ack; logic [7:0] d;
    bus_start();
    wbyte(8'h12, ack); chk({"R1 ", req}, ack, 0);
    wbyte(p, ack);     chk({"R3 ", req}, ack, 0);
    exp_ptr = p[2:0];
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      wbyte(d, ack, glitch); chk({"R3 ", req}, ack, 0);
      exp_mem[exp_ptr] = d;
      exp_ptr = step(exp_ptr);
    end
    bus_stop();
    for (int a = 0; a < 8; a++) chk({"R3 contents ", req}, mem[a], exp_mem[a]);
  endtask

  task automatic do_read(input bit combined, input logic [7:0] p, input int n, input string req);
    logic ack; logic [7:0] d;
    bus_start();
    if (combined) begin
      wbyte(8'h12, ack); chk({"R6 ", req}, ack, 0);
      wbyte(p, ack);     chk({"R6 ", req}, ack, 0);
      exp_ptr = p[2:0];
      bus_rstart();
    end
    wbyte(8'h13, ack); chk({"R1 ", req}, ack, 0);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i < n - 1);
      chk({"R7 ", req}, d, exp_mem[exp_ptr]);
      exp_ptr = step(exp_ptr);
    end
    bus_stop();
    chk({"R7 released ", req}, sda_oe, 0);
  endtask

  initial begin
    logic ack; logic [7:0] d; int snap;
    void'($urandom(32'd1234));
    exp_ptr = 3'd0;
    // R9: bus activity while reset held
    w(5);
    chk("R9 reset sda_oe", sda_oe, 0);
    bus_start(); wbyte(8'h12, ack); wbyte(8'h00, ack); wbyte(8'hA5, ack); bus_stop();
    chk("R9 no ack in reset", ack, 1);
    chk("R9 no write in reset", we_cnt, 0);
    chk("R9 sda_oe in reset", sda_oe, 0);
    ext_rst_n = 1'b1; w(Q);

    do_read(0, 0, 2, "R5 read from reset pointer 0");
    do_write(8'h03, 3, "burst at 3");
    do_read(1, 8'h03, 3, "combined read at 3");
    do_read(0, 0, 1, "R5 plain read continues");
    do_write(8'h06, 3, "R4 write wraps");
    do_read(0, 0, 1, "R5 after wrap");
    do_read(1, 8'h07, 2, "R4 read wraps");

    // R2: wrong address ignored
    snap = we_cnt;
    do d = 8'($urandom); while (d[7:1] == 7'h09);
    bus_start(); wbyte(d, ack); chk("R2 no ack on mismatch", ack, 1);
    wbyte(8'h01, ack); chk("R2 no ack after mismatch", ack, 1);
    wbyte(8'h5A, ack); chk("R2 no ack after mismatch", ack, 1);
    bus_stop();
    chk("R2 no write", we_cnt, snap);
    do_read(0, 0, 1, "R2 pointer intact");

    // R8: STOP in the middle of a data byte
    bus_start(); wbyte(8'h12, ack); wbyte(8'h02, ack); exp_ptr = 3'd2;
    snap = we_cnt;
    for (int i = 0; i < 4; i++) wbit(1'b0, 0);
    bus_stop();
    chk("R8 released after stop", sda_oe, 0);
    chk("R8 no partial write", we_cnt, snap);
    do_read(0, 0, 1, "R8 pointer after stop abort");

    // R8: repeated START in the middle of a data byte
    bus_start(); wbyte(8'h12, ack); wbyte(8'h05, ack); exp_ptr = 3'd5;
    snap = we_cnt;
    for (int i = 0; i < 3; i++) wbit(1'b1, 0);
    bus_rstart();
    wbyte(8'h13, ack); chk("R8 ack after restart", ack, 0);
    rbyte(d, 0); chk("R8 data after restart abort", d, exp_mem[exp_ptr]);
    exp_ptr = step(exp_ptr);
    bus_stop();
    chk("R8 no partial write on restart", we_cnt, snap);

    // R10: short glitches on both lines
    do_write(8'h01, 2, "R10 glitched bytes", 1);
    do_read(1, 8'h01, 2, "R10 readback");

    // random mix
    for (int t = 0; t < 16; t++) begin
      int kind = int'($urandom_range(0, 2));
      int n = int'($urandom_range(1, 4));
      logic [7:0] p = 8'($urandom);
      if (kind == 0) do_write(p, n, "random write");
      else if (kind == 1) do_read(1, p, n, "R6 random combined");
      else do_read(0, 0, n, "R5 random plain");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1;
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R7 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule